// File: doc/BRIEF.md
# Host Access Port for Microcontroller RAM

This block sits between a host register bus and the 256-byte instruction/data RAM of an embedded microcontroller. The host gets six small registers: a control register, a power-status register, a write pointer, a write-data window, a read pointer and a read-data window. Through them it can stream bytes into the RAM or fetch bytes out of it. Each pointer has its own auto-increment enable, so a block of bytes needs only one address setup. One example is a five-byte record holding an interface version, the high and low bytes of a year, a month and a day, which is read back-to-back from a single start offset.

The RAM normally rests in a dynamic sleep state. Setting the host-enable bit wakes it. After a fixed number of cycles the power-status field reads zero, and only from then on are data accesses accepted. A data access made while the RAM is still waking is dropped and sets a sticky error flag. Clearing host-enable lets the RAM go back to sleep. The microcontroller has its own simple byte port, which is served only while host access is off. When both sides request in the same cycle, the host's data access blocks the microcontroller port.

Top module: `ucram_host_port`

## Requirements
- R1: After reset, the control register reads 0, the power-status register reads 2 (asleep), the error flag is clear and both pointers are 0.
- R2: Control register (address 0) bit fields: bit 0 is host-enable, bit 1 is write auto-increment, bit 2 is read auto-increment, and bit 8 is the sticky error flag. A write with bit 8 set clears the flag. The register reads back exactly these bits.
- R3: Power-status (address 1, bits 1:0) reads 2 while host-enable is 0. After a control write that sets host-enable from 0, it reads 1 for WAKE_CYC cycles and then reads 0. Clearing host-enable returns it to 2 on the same edge.
- R4: A write to the write pointer (address 2) loads the byte offset. A write to the write-data window (address 3) stores bits 7:0 of the written value at that offset.
- R5: With write auto-increment set, each accepted data write advances the write pointer by one, wrapping from 0xFF to 0x00. With it clear, the pointer holds.
- R6: A write to the read pointer (address 4) sets the read offset. A read of the read-data window (address 5) returns the byte at that offset in bits 7:0, with the upper bits zero, on reg_rdata the cycle after the read strobe.
- R7: With read auto-increment set, consecutive reads of the read-data window return consecutive bytes, and the offset wraps from 0xFF to 0x00.
- R8: A data-window access made while host-enable is 1 but power-status is not 0 leaves the RAM and the pointers untouched, returns 0, and sets the sticky error flag.
- R9: A data-window access made while host-enable is 0 leaves the RAM and the pointers untouched, returns 0, and does not set the error flag.
- R10: The microcontroller port is granted only while host-enable is 0 and no host data-window access is made in that cycle. A granted read returns the byte on uc_rdata after the next edge. A granted write stores uc_wdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Host register select |
| reg_wr | input | 1 | Host register write strobe |
| reg_rd | input | 1 | Host register read strobe |
| reg_wdata | input | BUS_W | Host write data |
| reg_rdata | output | BUS_W | Host read data, updated the cycle after reg_rd |
| uc_req | input | 1 | Microcontroller RAM request |
| uc_we | input | 1 | Microcontroller write (1) or read (0) |
| uc_addr | input | OFS_W | Microcontroller byte offset |
| uc_wdata | input | 8 | Microcontroller write byte |
| uc_gnt | output | 1 | Microcontroller request served this cycle |
| uc_rdata | output | 8 | Microcontroller read byte |

## Verification
The bench goes after the wake window. It counts the exact number of cycles the power field stays non-zero, because a design with an off-by-one wake counter would either accept data a cycle early or reject a legal access. It also writes data while the RAM is waking and while host access is off, then reads the same byte back and re-reads the pointer. A design that only suppressed the read data, and still let the write or the pointer step through, is caught this way. Auto-increment is exercised across the 0xFF to 0x00 wrap and with the increment disabled, so a pointer that saturates or always steps shows up. The microcontroller port is driven in the same cycle as a host data access, and while the host is enabled, to catch a missing priority.

// File: rtl/ucram_pkg.sv
package ucram_pkg;

  typedef enum logic [2:0] {
    RA_CTRL  = 3'd0,
    RA_PWR   = 3'd1,
    RA_WPTR  = 3'd2,
    RA_WDATA = 3'd3,
    RA_RPTR  = 3'd4,
    RA_RDATA = 3'd5
  } reg_addr_e;

  typedef enum logic [1:0] {
    PW_AWAKE  = 2'd0,
    PW_WAKING = 2'd1,
    PW_ASLEEP = 2'd2
  } pwr_e;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_WINC_BIT = 1;
  localparam int CTRL_RINC_BIT = 2;
  localparam int CTRL_ERR_BIT  = 8;

endpackage

// File: rtl/ucram_pwr.sv
module ucram_pwr
  import ucram_pkg::*;
#(
  parameter int WAKE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_next,
  output pwr_e state
);

  localparam int CW = $clog2(WAKE_CYC + 1);

  pwr_e          state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (!en_next) begin
      state_d = PW_ASLEEP;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        PW_ASLEEP: begin
          state_d = PW_WAKING;
          cnt_d   = CW'(WAKE_CYC - 1);
        end
        PW_WAKING: begin
          if (cnt_q == '0) state_d = PW_AWAKE;
          else             cnt_d   = cnt_q - 1'b1;
        end
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PW_ASLEEP;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state = state_q;

endmodule

// File: rtl/ucram_ptr.sv
module ucram_ptr #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  output logic [AW-1:0] ptr
);

  logic [AW-1:0] ptr_q, ptr_d;
  logic          ptr_ce;

  always_comb begin
    ptr_ce = load | step;
    ptr_d  = load ? load_val : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_ce) ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

endmodule

// File: rtl/ucram_ram.sv
module ucram_ram #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_waddr,
  input  logic [7:0]    a_wdata,
  input  logic [AW-1:0] a_raddr,
  output logic [7:0]    a_rdata,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [7:0]    b_wdata,
  output logic [7:0]    b_rdata
);

  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_we)      mem[a_waddr] <= a_wdata;
    else if (b_we) mem[b_addr]  <= b_wdata;
  end

  assign a_rdata = mem[a_raddr];
  assign b_rdata = mem[b_addr];

endmodule

// File: rtl/ucram_host_port.sv
module ucram_host_port
  import ucram_pkg::*;
#(
  parameter int BUS_W    = 32,
  parameter int OFS_W    = 8,
  parameter int WAKE_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       reg_addr,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [BUS_W-1:0] reg_wdata,
  output logic [BUS_W-1:0] reg_rdata,
  input  logic             uc_req,
  input  logic             uc_we,
  input  logic [OFS_W-1:0] uc_addr,
  input  logic [7:0]       uc_wdata,
  output logic             uc_gnt,
  output logic [7:0]       uc_rdata
);

  logic host_en_q, host_en_d;
  logic winc_q, winc_d;
  logic rinc_q, rinc_d;
  logic err_q, err_d;
  logic [BUS_W-1:0] rdata_q, rdata_d;
  logic [7:0]       uc_rdata_q, uc_rdata_d;

  logic ctrl_wr, wdat_hit, rdat_hit, data_ok, set_err;
  logic wptr_ld, rptr_ld, wptr_step, rptr_step, host_we, uc_wr;
  logic [OFS_W-1:0] wptr, rptr;
  logic [7:0] ram_a_rd, ram_b_rd;
  pwr_e pwr_state;

  always_comb begin
    ctrl_wr   = reg_wr & (reg_addr == RA_CTRL);
    wptr_ld   = reg_wr & (reg_addr == RA_WPTR);
    rptr_ld   = reg_wr & (reg_addr == RA_RPTR);
    wdat_hit  = reg_wr & (reg_addr == RA_WDATA);
    rdat_hit  = reg_rd & (reg_addr == RA_RDATA);
    data_ok   = host_en_q & (pwr_state == PW_AWAKE);
    set_err   = host_en_q & (pwr_state != PW_AWAKE) & (wdat_hit | rdat_hit);
    host_we   = wdat_hit & data_ok;
    wptr_step = host_we & winc_q;
    rptr_step = rdat_hit & data_ok & rinc_q;
    uc_gnt    = uc_req & ~host_en_q & ~wdat_hit & ~rdat_hit;
    uc_wr     = uc_gnt & uc_we;
  end

  always_comb begin
    host_en_d = ctrl_wr ? reg_wdata[CTRL_EN_BIT]   : host_en_q;
    winc_d    = ctrl_wr ? reg_wdata[CTRL_WINC_BIT] : winc_q;
    rinc_d    = ctrl_wr ? reg_wdata[CTRL_RINC_BIT] : rinc_q;
    if (set_err)                                err_d = 1'b1;
    else if (ctrl_wr && reg_wdata[CTRL_ERR_BIT]) err_d = 1'b0;
    else                                         err_d = err_q;
  end

  always_comb begin
    rdata_d = rdata_q;
    if (reg_rd) begin
      rdata_d = '0;
      unique case (reg_addr)
        RA_CTRL: begin
          rdata_d[CTRL_EN_BIT]   = host_en_q;
          rdata_d[CTRL_WINC_BIT] = winc_q;
          rdata_d[CTRL_RINC_BIT] = rinc_q;
          rdata_d[CTRL_ERR_BIT]  = err_q;
        end
        RA_PWR:   rdata_d[1:0]       = pwr_state;
        RA_WPTR:  rdata_d[OFS_W-1:0] = wptr;
        RA_RPTR:  rdata_d[OFS_W-1:0] = rptr;
        RA_RDATA: rdata_d[7:0]       = data_ok ? ram_a_rd : 8'h00;
        default:  rdata_d = '0;
      endcase
    end
    uc_rdata_d = (uc_gnt && !uc_we) ? ram_b_rd : uc_rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_en_q  <= 1'b0;
      winc_q     <= 1'b0;
      rinc_q     <= 1'b0;
      err_q      <= 1'b0;
      rdata_q    <= '0;
      uc_rdata_q <= '0;
    end else begin
      host_en_q  <= host_en_d;
      winc_q     <= winc_d;
      rinc_q     <= rinc_d;
      err_q      <= err_d;
      rdata_q    <= rdata_d;
      uc_rdata_q <= uc_rdata_d;
    end
  end

  ucram_pwr #(.WAKE_CYC(WAKE_CYC)) u_pwr (
    .clk(clk), .rst_n(rst_n), .en_next(host_en_d), .state(pwr_state)
  );

  ucram_ptr #(.AW(OFS_W)) u_wptr (
    .clk(clk), .rst_n(rst_n), .load(wptr_ld),
    .load_val(reg_wdata[OFS_W-1:0]), .step(wptr_step), .ptr(wptr)
  );

  ucram_ptr #(.AW(OFS_W)) u_rptr (
    .clk(clk), .rst_n(rst_n), .load(rptr_ld),
    .load_val(reg_wdata[OFS_W-1:0]), .step(rptr_step), .ptr(rptr)
  );

  ucram_ram #(.AW(OFS_W)) u_ram (
    .clk(clk),
    .a_we(host_we), .a_waddr(wptr), .a_wdata(reg_wdata[7:0]),
    .a_raddr(rptr), .a_rdata(ram_a_rd),
    .b_we(uc_wr), .b_addr(uc_addr), .b_wdata(uc_wdata), .b_rdata(ram_b_rd)
  );

  assign reg_rdata = rdata_q;
  assign uc_rdata  = uc_rdata_q;

endmodule

// File: rtl/ucram_host_port_chk.sv
module ucram_host_port_chk #(
  parameter int BUS_W = 32,
  parameter int OFS_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       reg_addr,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic [BUS_W-1:0] reg_wdata,
  input logic [BUS_W-1:0] reg_rdata,
  input logic             uc_gnt,
  input logic             host_en,
  input logic             err,
  input logic [1:0]       pwr,
  input logic [OFS_W-1:0] wptr,
  input logic [OFS_W-1:0] rptr
);

  p_asleep_when_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !host_en |-> pwr == 2'd2);

  p_wake_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_en) |-> pwr == 2'd1);

  p_uc_excluded_r10: assert property (@(posedge clk) disable iff (!rst_n)
    host_en |-> !uc_gnt);

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err && !(reg_wr && reg_addr == 3'd0 && reg_wdata[8]) |=> err);

  p_rd_pad_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && reg_addr == 3'd5 |=> reg_rdata[BUS_W-1:8] == '0);

  p_off_read_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && reg_addr == 3'd5 && !host_en |=> reg_rdata == '0);

  p_wptr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && (reg_addr == 3'd2 || reg_addr == 3'd3)) |=> $stable(wptr));

  p_rptr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == 3'd4) && !(reg_rd && reg_addr == 3'd5)
    |=> $stable(rptr));

endmodule

bind ucram_host_port ucram_host_port_chk #(.BUS_W(BUS_W), .OFS_W(OFS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .uc_gnt(uc_gnt), .host_en(host_en_q), .err(err_q), .pwr(pwr_state),
  .wptr(wptr), .rptr(rptr)
);

// File: tb/test_ucram_host_port.sv
module test_ucram_host_port;

  localparam int BUS_W = 32;
  localparam int OFS_W = 8;
  localparam int WAKE  = 4;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [2:0]       reg_addr;
  logic             reg_wr, reg_rd;
  logic [BUS_W-1:0] reg_wdata, reg_rdata;
  logic             uc_req, uc_we;
  logic [OFS_W-1:0] uc_addr;
  logic [7:0]       uc_wdata, uc_rdata;
  logic             uc_gnt;

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] model [256];
  logic [31:0] v;

  always #2 clk = ~clk;

  ucram_host_port #(.BUS_W(BUS_W), .OFS_W(OFS_W), .WAKE_CYC(WAKE)) i_ucram_host_port (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .uc_req(uc_req), .uc_we(uc_we), .uc_addr(uc_addr), .uc_wdata(uc_wdata),
    .uc_gnt(uc_gnt), .uc_rdata(uc_rdata)
  );

  function automatic logic [31:0] ctrl_word(bit en, bit wi, bit ri, bit clr);
    return {23'd0, clr, 5'd0, ri, wi, en};
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %0h exp %0h", req, got, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic reg_write(logic [2:0] a, logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(logic [2:0] a, output logic [31:0] d);
    reg_addr = a; reg_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic enable_and_wait(bit wi, bit ri);
    reg_write(3'd0, ctrl_word(1'b1, wi, ri, 1'b0));
    repeat (WAKE + 1) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog got 0 exp 1");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    v = $urandom(32'd2024);
    rst_n = 1'b0; reg_addr = '0; reg_wr = 0; reg_rd = 0; reg_wdata = '0;
    uc_req = 0; uc_we = 0; uc_addr = '0; uc_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    reg_read(3'd0, v); check("R1 ctrl", v, 32'h0);
    reg_read(3'd1, v); check("R1 pwr", v, 32'd2);
    reg_read(3'd2, v); check("R1 wptr", v, 32'd0);
    reg_read(3'd4, v); check("R1 rptr", v, 32'd0);

    // R3 wake window, R8 access while waking
    reg_write(3'd2, 32'h10);
    reg_write(3'd0, ctrl_word(1'b1, 1'b0, 1'b0, 1'b0));
    for (int i = 0; i < WAKE; i++) begin
      reg_read(3'd1, v); check("R3 waking", v, 32'd1);
    end
    reg_read(3'd1, v); check("R3 awake", v, 32'd0);
    reg_write(3'd3, 32'hFFFF_FFAA);
    reg_read(3'd4, v);
    reg_write(3'd4, 32'h10);
    reg_read(3'd5, v); check("R4 stored byte", v, 32'hAA);
    reg_read(3'd0, v); check("R2 ctrl readback", v, 32'h1);

    reg_write(3'd0, ctrl_word(1'b0, 1'b0, 1'b0, 1'b0));
    reg_read(3'd1, v); check("R3 sleep after clear", v, 32'd2);
    reg_write(3'd0, ctrl_word(1'b1, 1'b0, 1'b0, 1'b0));
    reg_write(3'd3, 32'h77);
    reg_read(3'd5, v); check("R8 read while waking", v, 32'h0);
    repeat (WAKE) @(negedge clk);
    reg_read(3'd0, v); check("R8 sticky err", v, 32'h101);
    reg_read(3'd5, v); check("R8 byte untouched", v, 32'hAA);
    reg_write(3'd0, ctrl_word(1'b1, 1'b0, 1'b0, 1'b1));
    reg_read(3'd0, v); check("R2 err cleared", v, 32'h1);

    // R9 accesses with host disabled
    reg_write(3'd0, ctrl_word(1'b0, 1'b1, 1'b1, 1'b0));
    reg_write(3'd3, 32'h55);
    reg_read(3'd5, v); check("R9 read returns 0", v, 32'h0);
    reg_read(3'd2, v); check("R9 wptr unchanged", v, 32'h10);
    reg_read(3'd4, v); check("R9 rptr unchanged", v, 32'h10);
    reg_read(3'd0, v); check("R9 no err", v, 32'h6);
    enable_and_wait(1'b0, 1'b0);
    reg_read(3'd5, v); check("R9 byte untouched", v, 32'hAA);
    model[8'h10] = 8'hAA;

    // R5/R7 no increment: overwrite same offset, repeat read
    reg_write(3'd2, 32'h40);
    reg_write(3'd3, 32'h11);
    reg_write(3'd3, 32'h22);
    reg_read(3'd2, v); check("R5 wptr holds", v, 32'h40);
    reg_write(3'd4, 32'h40);
    reg_read(3'd5, v); check("R7 no-inc read", v, 32'h22);
    reg_read(3'd5, v); check("R7 no-inc reread", v, 32'h22);
    model[8'h40] = 8'h22;

    // R5/R7 wrap at the top of the RAM
    reg_write(3'd0, ctrl_word(1'b1, 1'b1, 1'b1, 1'b0));
    reg_write(3'd2, 32'hFE);
    for (int i = 0; i < 3; i++) begin
      reg_write(3'd3, 32'hC0 + i);
      model[8'(8'hFE + i)] = 8'(8'hC0 + i);
    end
    reg_read(3'd2, v); check("R5 wptr wrap", v, 32'h01);
    reg_write(3'd4, 32'hFE);
    for (int i = 0; i < 3; i++) begin
      reg_read(3'd5, v); check("R7 wrap read", v, 32'hC0 + i);
    end
    reg_read(3'd4, v); check("R7 rptr wrap", v, 32'h01);

    // R7 five-byte record read back-to-back
    reg_write(3'd2, 32'hF1);
    reg_write(3'd3, 32'h03); reg_write(3'd3, 32'h07);
    reg_write(3'd3, 32'hE8); reg_write(3'd3, 32'h0B);
    reg_write(3'd3, 32'h1C);
    model[8'hF1] = 8'h03; model[8'hF2] = 8'h07; model[8'hF3] = 8'hE8;
    model[8'hF4] = 8'h0B; model[8'hF5] = 8'h1C;
    reg_write(3'd4, 32'hF1);
    for (int i = 0; i < 5; i++) begin
      reg_read(3'd5, v); check("R7 record", v, {24'd0, model[8'(8'hF1 + i)]});
    end

    // R4/R6 random bursts
    for (int r = 0; r < 8; r++) begin
      logic [7:0] off;
      int n;
      off = 8'($urandom);
      n   = 1 + ($urandom % 12);
      reg_write(3'd2, {24'd0, off});
      for (int i = 0; i < n; i++) begin
        logic [31:0] d;
        d = $urandom;
        reg_write(3'd3, d);
        model[8'(off + i)] = d[7:0];
      end
      reg_write(3'd4, {24'd0, off});
      for (int i = 0; i < n; i++) begin
        reg_read(3'd5, v); check("R6 random readback", v, {24'd0, model[8'(off + i)]});
      end
    end

    // R10 microcontroller port
    uc_req = 1; uc_we = 1; uc_addr = 8'h20; uc_wdata = 8'h5A;
    #1; check("R10 blocked while host on", {31'd0, uc_gnt}, 32'd0);
    @(negedge clk);
    reg_write(3'd0, ctrl_word(1'b0, 1'b0, 1'b0, 1'b0));
    #1; check("R10 granted when off", {31'd0, uc_gnt}, 32'd1);
    @(negedge clk);
    uc_we = 0; uc_addr = 8'h10;
    reg_addr = 3'd5; reg_rd = 1'b1;
    #1; check("R10 host wins", {31'd0, uc_gnt}, 32'd0);
    @(negedge clk);
    reg_rd = 1'b0;
    uc_addr = 8'h20;
    @(negedge clk);
    check("R10 uc read", {24'd0, uc_rdata}, 32'h5A);
    uc_req = 0;
    enable_and_wait(1'b0, 1'b0);
    reg_write(3'd4, 32'h20);
    reg_read(3'd5, v); check("R10 uc write seen by host", v, 32'h5A);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule